// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block builds the byte that a flash array returns on a read while an internal program or erase operation is running, is waiting in the sector-erase collection window, or has stopped after overrunning its time limit. It combines the operation type, the busy and window-open indications, the time-limit-exceeded indication and bit 7 of the byte being programmed into one status word. Each reported property takes its own bit: complement-data polling, a toggle on every read, a failure flag, the step that failed, and a flag for whether the erase has started.

A select output tells the read path whether to drive the status word or true array data. The select goes low as soon as none of the three activity conditions holds, so the host's next read sees real contents. The read strobe feeds an internal toggle flip-flop. Two back-to-back reads during an operation therefore return different values in bit 6. The busy, window and exceeded conditions are made elsewhere and arrive here as levels. The exceeded level is expected to stay high until the controller sees a reset command, and the select stays on status for as long as it does.

Top module: `status_flag_gen`

## Requirements
- R1: `status_sel_o` is 1 exactly when at least one of `busy_i`, `window_open_i` or `exceeded_i` is 1, in the same cycle.
- R2: While `status_sel_o` is 0, `status_o` is 8'h00.
- R3: While status is selected and `op_erase_i` is 0 (program), bit 7 of `status_o` is the inverse of `prog_d7_i`.
- R4: While status is selected and `op_erase_i` is 1 (erase), bit 7 of `status_o` is 0.
- R5: When status is selected and `rd_strobe_i` is sampled 0 at a clock edge after being sampled 1 at the previous edge, bit 6 of `status_o` inverts after that edge.
- R6: Bit 6 keeps its value across any clock edge with no such falling strobe, and across every edge where status is not selected.
- R7: While status is selected, bit 5 of `status_o` equals `exceeded_i`.
- R8: While status is selected, bit 4 of `status_o` is `op_erase_i` when `exceeded_i` is 1, and 0 otherwise.
- R9: While status is selected, bit 3 of `status_o` is 1 for an erase with `window_open_i` at 0, and 0 during the window or for a program.
- R10: Bits 2 to 0 of `status_o` are always 0.
- R11: After `rst_ni` is asserted low, the toggle bit and the stored strobe level are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_erase_i | input | 1 | Operation type: 0 program, 1 erase |
| busy_i | input | 1 | Embedded algorithm running |
| window_open_i | input | 1 | Sector-erase collection window open |
| exceeded_i | input | 1 | Operation overran its time limit |
| prog_d7_i | input | 1 | Bit 7 of the byte being programmed |
| rd_strobe_i | input | 1 | Read strobe, level, sampled on clk_i |
| status_o | output | 8 | Status word |
| status_sel_o | output | 1 | 1: return status_o, 0: return array data |

## Verification
The only state is the toggle bit and the stored strobe level. A wrong value in either shows at the ports the edge after a falling strobe. Bit 6 then fails to invert, inverts without a falling strobe, or inverts while the block is idle. A mismatch appears no later than the next active read. All other bits are combinational functions of the inputs, and the bench compares them on every cycle across all input combinations.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned FAIL_BIT = 5;
  localparam int unsigned STEP_BIT = 4;
  localparam int unsigned ERST_BIT = 3;
  localparam int unsigned RSV_W    = 3;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;
endpackage

// File: rtl/status_toggle.sv
module status_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic strobe_i,
  output logic toggle_o
);
  logic strobe_q;
  logic tog_q;
  logic fall;

  assign fall = strobe_q & ~strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      if (fall && active_i) tog_q <= ~tog_q;
    end
  end

  assign toggle_o = tog_q;

  a_r5_flip_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && strobe_q && !strobe_i) |=> (toggle_o != $past(toggle_o)));

  a_r6_hold_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i || !strobe_q || strobe_i) |=> $stable(toggle_o));
endmodule

// File: rtl/status_encoder.sv
module status_encoder
  import status_flag_pkg::*;
(
  input  logic              active_i,
  input  op_kind_e          op_i,
  input  logic              window_open_i,
  input  logic              exceeded_i,
  input  logic              prog_d7_i,
  input  logic              toggle_i,
  output logic [STAT_W-1:0] word_o
);
  logic [STAT_W-1:0] raw;

  always_comb begin
    raw           = '0;
    raw[POLL_BIT] = (op_i == OP_ERASE) ? 1'b0 : ~prog_d7_i;
    raw[TOG_BIT]  = toggle_i;
    raw[FAIL_BIT] = exceeded_i;
    raw[STEP_BIT] = exceeded_i & (op_i == OP_ERASE);
    raw[ERST_BIT] = (op_i == OP_ERASE) & ~window_open_i;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_gate
    if (i < RSV_W) begin : g_rsv
      assign word_o[i] = 1'b0;
    end else begin : g_bit
      assign word_o[i] = raw[i] & active_i;
    end
  end
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
  import status_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_erase_i,
  input  logic              busy_i,
  input  logic              window_open_i,
  input  logic              exceeded_i,
  input  logic              prog_d7_i,
  input  logic              rd_strobe_i,
  output logic [STAT_W-1:0] status_o,
  output logic              status_sel_o
);
  logic     active;
  logic     toggle;
  op_kind_e op_kind;

  assign active       = busy_i | window_open_i | exceeded_i;
  assign status_sel_o = active;
  assign op_kind      = op_kind_e'(op_erase_i);

  status_toggle u_toggle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .strobe_i (rd_strobe_i),
    .toggle_o (toggle)
  );

  status_encoder u_enc (
    .active_i      (active),
    .op_i          (op_kind),
    .window_open_i (window_open_i),
    .exceeded_i    (exceeded_i),
    .prog_d7_i     (prog_d7_i),
    .toggle_i      (toggle),
    .word_o        (status_o)
  );

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_sel_o |-> (status_o == '0));

  a_r3_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_sel_o && !op_erase_i) |-> (status_o[POLL_BIT] == !prog_d7_i));

  a_r4_erase_poll_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_sel_o && op_erase_i) |-> !status_o[POLL_BIT]);

  a_r8_step_needs_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STEP_BIT] |-> status_o[FAIL_BIT]);

  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[RSV_W-1:0] == '0);
endmodule

// File: tb/tb_status_flag_gen.sv
module tb_status_flag_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_erase_i = 1'b0;
  logic       busy_i = 1'b0;
  logic       window_open_i = 1'b0;
  logic       exceeded_i = 1'b0;
  logic       prog_d7_i = 1'b0;
  logic       rd_strobe_i = 1'b0;
  logic [7:0] status_o;
  logic       status_sel_o;

  int checks = 0;
  int errors = 0;
  bit m_tog = 0;
  bit m_prev = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  status_flag_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_erase_i(op_erase_i), .busy_i(busy_i),
    .window_open_i(window_open_i), .exceeded_i(exceeded_i),
    .prog_d7_i(prog_d7_i), .rd_strobe_i(rd_strobe_i),
    .status_o(status_o), .status_sel_o(status_sel_o)
  );

  // reference model of the toggle state
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tog  = 0;
      m_prev = 0;
    end else begin
      if (m_prev && !rd_strobe_i && (busy_i || window_open_i || exceeded_i))
        m_tog = !m_tog;
      m_prev = rd_strobe_i;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit act;
    logic [7:0] e;
    act = busy_i || window_open_i || exceeded_i;
    chk("R1 select", {7'd0, status_sel_o}, {7'd0, act});
    if (!act) begin
      chk("R2 idle word", status_o, 8'h00);
    end else begin
      e = 8'h00;
      e[7] = op_erase_i ? 1'b0 : !prog_d7_i;
      e[6] = m_tog;
      e[5] = exceeded_i;
      e[4] = exceeded_i && op_erase_i;
      e[3] = op_erase_i && !window_open_i;
      chk(op_erase_i ? "R4 erase poll" : "R3 program poll", {7'd0, status_o[7]}, {7'd0, e[7]});
      chk("R5/R6 toggle", {7'd0, status_o[6]}, {7'd0, e[6]});
      chk("R7 fail flag", {7'd0, status_o[5]}, {7'd0, e[5]});
      chk("R8 step flag", {7'd0, status_o[4]}, {7'd0, e[4]});
      chk("R9 erase started", {7'd0, status_o[3]}, {7'd0, e[3]});
    end
    chk("R10 reserved", {5'd0, status_o[2:0]}, 8'h00);
  endtask

  task automatic step(input bit er, input bit bz, input bit wn, input bit ex,
                      input bit d7, input bit st);
    @(negedge clk_i);
    compare_all();
    op_erase_i = er; busy_i = bz; window_open_i = wn;
    exceeded_i = ex; prog_d7_i = d7; rd_strobe_i = st;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset state; a read pulse while active shows toggle starts at 0
    busy_i = 1'b1;
    #1;
    chk("R11 reset toggle", {7'd0, status_o[6]}, 8'h00);
    chk("R11 reset sel", {7'd0, status_sel_o}, 8'h01);
    rst_ni = 1'b1;
    // program, data bit 1, four reads
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 1, i[0]);
    // program, data bit 0
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, i[0]);
    // idle reads: toggle must hold (R6)
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, i[0]);
    // sector erase window then erase running
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 0, i[0]);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, i[0]);
    // long strobe, no fall: hold
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 1);
    // exceeded during program, then during erase
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 1, i[0]);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, i[0]);
    // mid-run reset (R11)
    step(0, 1, 0, 0, 0, 1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 reset toggle mid-run", {7'd0, status_o[6]}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_strobe_i = 1'b0;
    // random mix
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 5) == 0), $urandom_range(0, 1), $urandom_range(0, 1));
    step(0, 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule